// File: doc/BRIEF.md
# Four-Channel Timer with Pulse Accumulator

This block is a timer peripheral built around one 16-bit free-running counter. A prescaler divides the system clock by a power of two from 1 to 128 before it reaches the counter. Four channels share the counter. Each channel is set either to input capture or to output compare. In input capture, a selected edge on the channel's pin copies the counter into the channel register. In output compare, the channel acts on its output pin when the counter reaches the value in the channel register.

The last channel can be taken out of both modes and used as a pulse accumulator. It then counts selected edges on its pin in a separate 16-bit counter. Rollover of the main counter, rollover of the accumulator and every channel event each set a flag. Each flag has its own enable, which routes it to an interrupt output. This lets software extend timing past 16 bits, and it can measure one waveform while the block generates another.

A host reaches every register through a single-cycle write strobe and a combinational read path.

Top module: `gp_timer4`

## Requirements
- R1: After reset the counter, accumulator, all flags, all channel registers, all outputs `ch_out` and all interrupt outputs are zero.
- R2: CTRL (address 0) bit 0 runs the counter and bits 3:1 hold a select s. While running, the counter advances once every 2^s clocks; the prescaler phase restarts from zero each time the counter is stopped. While stopped, the counter holds.
- R3: When the counter advances from 0xFFFF to 0x0000, flag bit 4 in FLAGS (address 6) is set.
- R4: A channel in capture mode (its bit in MODE, address 2, is 0) copies the counter into its channel register (addresses 8 to 11) on each pin edge enabled by its 2-bit field in EDGE (address 3, bits 2i+1:2i): 01 rising, 10 falling, 11 both. The capture also sets its flag (FLAGS bit i). At divide 1 the stored value is the counter value two clocks after the pin change.
- R5: A pin edge that the channel's EDGE field does not select, including any edge with field 00, leaves the channel register and its flag unchanged.
- R6: A channel in compare mode (MODE bit i = 1) acts on `ch_out[i]` on the same clock edge on which the counter advances to its register value, and sets FLAGS bit i. The action comes from ACTION (address 4, bits 2i+1:2i): 01 toggle, 10 drive low, 11 drive high.
- R7: `ch_out` changes only when the counter advances. A host write to the counter, or a counter that is stopped, never fires a compare action, and a channel in capture mode never moves its output.
- R8: With MODE bit 4 set, channel 3 neither captures nor compares. Instead, each channel-3 edge selected by EDGE bits 7:6 adds one to the accumulator (address 7).
- R9: When the accumulator steps from 0xFFFF to 0x0000, FLAGS bit 5 is set.
- R10: Writing FLAGS clears exactly the bits written as 1. A flag set in the same cycle as the write stays set.
- R11: `irq_ch[i]`, `irq_ovf` and `irq_pacc` follow FLAGS bits i, 4 and 5 respectively, each gated by the same bit of IEN (address 5).
- R12: Capture on one channel and compare on another work at the same time from the one running counter.
- R13: A host write to the counter (address 1) or the accumulator (address 7) loads the written value, which reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| ch_in | input | 4 | Channel input pins, asynchronous |
| ch_out | output | 4 | Channel compare output pins |
| irq_ch | output | 4 | Per-channel interrupt requests |
| irq_ovf | output | 1 | Counter rollover interrupt request |
| irq_pacc | output | 1 | Accumulator rollover interrupt request |

## Verification
The assertions take two things for granted. First, a host write lasts exactly one cycle. Second, a pin level lasts long enough for the two-stage synchronizer to pass every edge, so the accumulator can move by at most one per clock. The stimulus meets both conditions: every write is a single strobe cycle, and every pin level is held for at least four clocks. Exact capture values are checked only at divide 1, with the pin changed just after the counter has been read. For every other capture, the counter is stopped, so the captured value does not depend on synchronizer phase.

// File: rtl/gp_timer4.sv
`timescale 1ns/1ps
module gp_timer4 #(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int PSW = 3,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] ch_out,
  output logic [NCH-1:0] irq_ch,
  output logic          irq_ovf,
  output logic          irq_pacc
);
  localparam int PCW = (1 << PSW) - 1;
  localparam int FW  = NCH + 2;
  localparam int CIW = $clog2(NCH);
  localparam int PA  = NCH - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_CNT = AW'(1), A_MODE = AW'(2),
    A_EDGE = AW'(3), A_ACT = AW'(4), A_IEN = AW'(5), A_FLG = AW'(6),
    A_PACC = AW'(7), A_CH0 = AW'(8);

  logic           run;
  logic [PSW-1:0] psel;
  logic [PCW-1:0] pre;
  logic [CW-1:0]  cnt, pacc;
  logic [NCH:0]   mode;
  logic [2*NCH-1:0] edg, act;
  logic [FW-1:0]  ien, flg;
  logic [CW-1:0]  chr [NCH];
  logic [NCH-1:0] s1, s2, s3, outr, hit, cap, evt;

  wire [PCW-1:0] pmask = ~({PCW{1'b1}} << psel);
  wire tick    = run && ((pre & pmask) == pmask);
  wire [CW-1:0] cnt_nx = cnt + 1'b1;
  wire pacc_on = mode[NCH];
  wire we_cnt  = wr_en && addr == A_CNT;
  wire we_pacc = wr_en && addr == A_PACC;
  wire [NCH-1:0] rise = s2 & ~s3;
  wire [NCH-1:0] fall = ~s2 & s3;
  wire pstep   = pacc_on && evt[PA];
  wire ovf_set = tick && !we_cnt && (cnt == {CW{1'b1}});
  wire pov_set = pstep && !we_pacc && (pacc == {CW{1'b1}});
  wire [FW-1:0] fset = {pov_set, ovf_set, hit | cap};
  wire [FW-1:0] fclr = (wr_en && addr == A_FLG) ? wdata[FW-1:0] : '0;
  wire [AW-1:0] cidx = addr - A_CH0;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      evt[i] = (edg[2*i] & rise[i]) | (edg[2*i+1] & fall[i]);
      hit[i] = tick && !we_cnt && mode[i] && !(i == PA && pacc_on) && (cnt_nx == chr[i]);
      cap[i] = evt[i] && !mode[i] && !(i == PA && pacc_on);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= ch_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; psel <= '0; mode <= '0; edg <= '0; act <= '0; ien <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: {psel, run} <= wdata[PSW:0];
        A_MODE: mode <= wdata[NCH:0];
        A_EDGE: edg <= wdata[2*NCH-1:0];
        A_ACT:  act <= wdata[2*NCH-1:0];
        A_IEN:  ien <= wdata[FW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (!run) pre <= '0;
    else          pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (we_cnt) cnt <= wdata;
    else if (tick)   cnt <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pacc <= '0;
    else if (we_pacc) pacc <= wdata;
    else if (pstep)   pacc <= pacc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else        flg <= (flg & ~fclr) | fset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) chr[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (wr_en && addr == A_CH0 + AW'(i)) chr[i] <= wdata;
        else if (cap[i])                    chr[i] <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outr <= '0;
    else
      for (int i = 0; i < NCH; i++)
        if (hit[i])
          case (act[2*i +: 2])
            2'b01: outr[i] <= ~outr[i];
            2'b10: outr[i] <= 1'b0;
            2'b11: outr[i] <= 1'b1;
            default: ;
          endcase
  end

  always_comb begin
    case (addr)
      A_CTRL: rdata = CW'({psel, run});
      A_CNT:  rdata = cnt;
      A_MODE: rdata = CW'(mode);
      A_EDGE: rdata = CW'(edg);
      A_ACT:  rdata = CW'(act);
      A_IEN:  rdata = CW'(ien);
      A_FLG:  rdata = CW'(flg);
      A_PACC: rdata = pacc;
      default: rdata = (addr >= A_CH0 && cidx < AW'(NCH)) ? chr[cidx[CIW-1:0]] : '0;
    endcase
  end

  assign ch_out   = outr;
  assign irq_ch   = flg[NCH-1:0] & ien[NCH-1:0];
  assign irq_ovf  = flg[NCH] & ien[NCH];
  assign irq_pacc = flg[NCH+1] & ien[NCH+1];
endmodule

module gp_timer4_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           run,
  input logic           tick,
  input logic [CW-1:0]  cnt,
  input logic [NCH+1:0] flg,
  input logic [NCH-1:0] ch_out,
  input logic [CW-1:0]  chr_last,
  input logic [CW-1:0]  pacc,
  input logic           pacc_on
);
  wire wc = wr_en && addr == AW'(1);
  wire wp = wr_en && addr == AW'(7);
  wire wl = wr_en && addr == AW'(8 + NCH - 1);

  p_count_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wc) |=> $stable(cnt));
  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wc && cnt == {CW{1'b1}}) |=> flg[NCH]);
  p_cmp_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_out[0] != $past(ch_out[0])) |-> flg[0]);
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ch_out));
  p_pacc_no_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pacc_on && !wl) |=> $stable(chr_last));
  p_pacc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wp |=> (pacc == $past(pacc) || pacc == $past(pacc) + 1'b1));
endmodule

bind gp_timer4 gp_timer4_chk #(.CW(CW), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .run(run), .tick(tick),
  .cnt(cnt), .flg(flg), .ch_out(ch_out), .chr_last(chr[NCH-1]), .pacc(pacc),
  .pacc_on(mode[NCH])
);

// File: tb/sim_gp_timer4.sv
`timescale 1ns/1ps
module sim_gp_timer4;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0, ch_in = 0;
  logic [15:0] wdata = 0, rdata;
  logic [3:0] ch_out, irq_ch;
  logic irq_ovf, irq_pacc;
  int checks = 0, errors = 0;
  logic [15:0] v, c0;

  gp_timer4 u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_in(ch_in), .ch_out(ch_out), .irq_ch(irq_ch),
    .irq_ovf(irq_ovf), .irq_pacc(irq_pacc));

  always #5 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pin_hold(input logic [3:0] p);
    ch_in = p; repeat (4) @(posedge clk);
  endtask

  task automatic t_reset;
    rd(1, v); chk("R1 count", v, 0);
    rd(6, v); chk("R1 flags", v, 0);
    rd(8, v); chk("R1 channel reg", v, 0);
    chk("R1 outputs", {ch_out, irq_ch, irq_ovf, irq_pacc}, 0);
  endtask

  task automatic t_prescale;
    wr(1, 16'h0000);
    wr(0, 16'h0007);
    repeat (64) @(posedge clk);
    rd(1, v); chk("R2 divide by 8", v, 16'd8);
    wr(0, 0);
    rd(1, c0); repeat (40) @(posedge clk);
    rd(1, v); chk("R2 stopped holds", v, c0);
    wr(1, 16'd100);
    wr(0, 16'h0001);
    repeat (10) @(posedge clk);
    rd(1, v); chk("R2 divide by 1", v, 16'd110);
    wr(0, 0);
  endtask

  task automatic t_overflow;
    wr(5, 16'h0010);
    wr(1, 16'hFFFE);
    rd(1, v); chk("R13 count load", v, 16'hFFFE);
    wr(0, 16'h0001);
    @(posedge clk); @(negedge clk); chk("R3 no flag before wrap", irq_ovf, 0);
    @(posedge clk); @(negedge clk); chk("R3 wrap sets flag", irq_ovf, 1);
    wr(0, 0);
    rd(6, v); chk("R3 flag bit 4", v[4], 1);
    wr(6, 16'h0010);
    chk("R10 cleared", irq_ovf, 0);
    wr(5, 16'h0000);
    wr(1, 16'hFFFF);
    wr(0, 16'h0001);
    repeat (3) @(posedge clk);
    wr(0, 0);
    rd(6, v); chk("R11 flag set while masked", v[4], 1);
    chk("R11 masked irq low", irq_ovf, 0);
    wr(5, 16'h0010);
    chk("R11 unmasked irq high", irq_ovf, 1);
    wr(6, 16'h003F); wr(5, 0);
  endtask

  task automatic t_capture;
    wr(2, 16'h0000);
    wr(3, 16'h0039);
    wr(9, 16'hAAAA); wr(10, 16'hBBBB); wr(11, 16'hCCCC); wr(8, 16'h0000);
    wr(1, 16'h1234);
    wr(6, 16'h003F);
    pin_hold(4'hF);
    rd(8, v);  chk("R4 rising capture", v, 16'h1234);
    rd(9, v);  chk("R5 falling-only ignores rise", v, 16'hAAAA);
    rd(10, v); chk("R4 both edges rise", v, 16'h1234);
    rd(11, v); chk("R5 field 00 ignores edge", v, 16'hCCCC);
    rd(6, v);  chk("R4 R5 flags after rise", v, 16'h0005);
    wr(1, 16'h2222);
    pin_hold(4'h0);
    rd(8, v);  chk("R5 rising-only ignores fall", v, 16'h1234);
    rd(9, v);  chk("R4 falling capture", v, 16'h2222);
    rd(10, v); chk("R4 both edges fall", v, 16'h2222);
    rd(6, v);  chk("R4 flags after fall", v, 16'h0007);
    wr(6, 16'h0001);
    rd(6, v);  chk("R10 partial clear", v, 16'h0006);
    wr(6, 16'h003F);
  endtask

  task automatic t_compare;
    wr(2, 16'h0003);
    wr(4, 16'h000D);
    wr(8, 16'd5); wr(9, 16'd3);
    wr(1, 16'd0);
    wr(5, 16'h0001);
    wr(0, 16'h0001);
    for (int m = 1; m <= 6; m++) begin
      @(negedge clk);
      if (m == 2) chk("R6 before match", ch_out, 4'b0000);
      if (m == 3) chk("R6 set at match", ch_out, 4'b0010);
      if (m == 4) chk("R6 toggle not yet", ch_out, 4'b0010);
      if (m == 5) chk("R6 toggle at match", ch_out, 4'b0011);
    end
    wr(0, 0);
    rd(6, v); chk("R6 compare flags", v, 16'h0003);
    chk("R11 channel irq", irq_ch, 4'b0001);
    wr(6, 16'h003F);
    wr(1, 16'd5);
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R7 host load no action", ch_out, 4'b0011);
    wr(4, 16'h0009);
    wr(9, 16'h0020);
    wr(1, 16'h001E);
    wr(0, 16'h0001);
    repeat (4) @(posedge clk);
    wr(0, 0);
    @(negedge clk); chk("R6 clear action", ch_out, 4'b0001);
    wr(6, 16'h003F); wr(5, 0);
  endtask

  task automatic t_concurrent;
    wr(2, 16'h0001);
    wr(4, 16'h0001);
    wr(3, 16'h0004);
    wr(8, 16'h0040);
    wr(1, 16'h0030);
    pin_hold(4'h0);
    wr(6, 16'h003F);
    wr(0, 16'h0001);
    rd(1, c0);
    ch_in = 4'b0010;
    repeat (40) @(posedge clk);
    wr(0, 0);
    rd(9, v); chk("R12 R4 capture while comparing", v, c0 + 16'd2);
    @(negedge clk); chk("R12 compare while capturing", ch_out[0], 1'b0);
    rd(6, v); chk("R12 both flags", v[1:0], 2'b11);
    pin_hold(4'h0);
    wr(6, 16'h003F);
  endtask

  task automatic t_pacc;
    wr(2, 16'h0010);
    wr(3, 16'h00C0);
    wr(11, 16'h7777);
    wr(7, 16'h0000);
    wr(6, 16'h003F);
    for (int k = 0; k < 5; k++) pin_hold(k[0] ? 4'h0 : 4'h8);
    rd(7, v);  chk("R8 both-edge count", v, 16'd5);
    rd(11, v); chk("R8 no capture in accumulator mode", v, 16'h7777);
    rd(6, v);  chk("R8 no channel flag", v[3], 1'b0);
    wr(3, 16'h0040);
    for (int k = 0; k < 4; k++) begin pin_hold(4'h0); pin_hold(4'h8); end
    rd(7, v);  chk("R8 rising-only count", v, 16'd9);
    wr(7, 16'hFFFF);
    rd(7, v);  chk("R13 accumulator load", v, 16'hFFFF);
    wr(5, 16'h0020);
    pin_hold(4'h0); pin_hold(4'h8);
    rd(7, v);  chk("R9 accumulator wraps", v, 16'h0000);
    chk("R9 accumulator overflow irq", irq_pacc, 1'b1);
    chk("R8 channel 3 output idle", ch_out[3], 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset;
    t_prescale;
    t_overflow;
    t_capture;
    t_compare;
    t_concurrent;
    t_pacc;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule